// File: doc/BRIEF.md
# Temperature threshold monitor

The block watches a stream of temperature samples, each tagged with a sensor number. For every sensor it keeps a lower, an upper and a critical limit, and it compares each new sample against them. The result of the latest comparison is held in three violation status bits per sensor. Three level interrupt lines, one per limit class, are the OR of all sensors' status bits that are neither masked nor being cleared, gated by a global enable per class. A line drops on its own when a later sample is back inside the limits.

Each sensor also keeps its last temperature, which reads back sign-extended. The temperature carries a valid flag that stays low for a fixed hold time after every new sample. A stall watchdog counts the cycles since the last accepted sample. When the programmed timeout expires it raises a bark status, bumps a bark counter and restarts. A simple single-cycle register port (write strobe, address, write data, combinational read data) gives access to all fields. Temperatures are signed values in tenths of a degree.

Top module: `thermal_limit_monitor`

## Requirements
- R1: After reset every status bit is 0, every valid flag is 0, every sensor's control field reads 0x0007 (all masks set, clears 0), the global enable (address 0x00) reads 0, the watchdog control (address 0x02) reads 0x0004, the bark count (address 0x03) reads 0, a lower limit reads 0xF800, and all four interrupt outputs are 0.
- R2: Per-sensor registers sit at address 0x80 + 8*sensor + field, with field 0 lower limit, 1 upper limit, 2 critical limit. On each sample for a sensor its status (field 4) is rewritten: bit0 lower is set when temp <= lower limit, bit1 upper when temp >= upper limit, bit2 critical when temp >= critical limit, all compared as signed values. The new status reads back from the cycle after the sample.
- R3: Global enable at address 0x00 has bit0 lower, bit1 upper, bit2 critical. An interrupt line is high exactly when some sensor has that status bit set, its mask bit clear and the class enabled. It falls when a later sample leaves that limit.
- R4: The control field (field 3) holds the mask bits in bits 2:0 (lower, upper, critical). A set mask bit keeps that sensor's status out of the interrupt line.
- R5: Control bits 5:3 are clear bits (lower, upper, critical). While a clear bit is held, the matching status bit is forced to 0 from the next cycle on, and samples do not set it. After release it stays 0 until the next sample.
- R6: Status bit3 is the valid flag. It is 0 before a sensor's first sample. After each sample it reads 0 for 6 cycles and then 1.
- R7: Field 5 returns the sensor's last sample, sign-extended to 16 bits.
- R8: With a nonzero timeout at address 0x01, if the timeout value T passes in cycles with no accepted sample, bark status (address 0x02 bit0) sets and the bark count (0x03) increments, saturating. The timer then restarts. Timeout 0 disables the watchdog.
- R9: Address 0x02 bit1 is the bark clear: while it is 1, bark status is 0, and the count is kept. Bit2 is the bark mask: irq_bark_o is bark status and not mask.
- R10: Samples whose sensor number is at or above the sensor count are ignored: no status, last-value or valid change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_id_i | input | 4 | Sensor number of the sample |
| smp_temp_i | input | 12 | Signed sample, tenths of a degree |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| irq_lower_o | output | 1 | Lower-limit interrupt level |
| irq_upper_o | output | 1 | Upper-limit interrupt level |
| irq_crit_o | output | 1 | Critical-limit interrupt level |
| irq_bark_o | output | 1 | Watchdog bark interrupt level |

## Verification
A sample's status, last value and valid drop are due one edge after the sample. Mask, enable and bark-mask writes act on the interrupt lines right after their write edge. A clear write zeroes status one edge later, the valid flag returns six edges after the sample, and a bark appears T edges after the last accepted sample. The bench drives inputs and reads the combinational register port at falling edges. It then counts exactly those edges before each sample is taken, checking the cycle just before each delayed result as well as the cycle it lands.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

    // limit class bit positions inside a 3-bit class vector
    localparam int unsigned CLS_LO = 0;
    localparam int unsigned CLS_UP = 1;
    localparam int unsigned CLS_CR = 2;
    localparam int unsigned NUM_CLS = 3;

    // per-sensor field codes (low three address bits)
    localparam logic [2:0] FLD_LOW  = 3'd0;
    localparam logic [2:0] FLD_UP   = 3'd1;
    localparam logic [2:0] FLD_CRIT = 3'd2;
    localparam logic [2:0] FLD_CTRL = 3'd3;
    localparam logic [2:0] FLD_STAT = 3'd4;
    localparam logic [2:0] FLD_LAST = 3'd5;

    // global addresses (address bit 7 clear)
    localparam logic [7:0] GA_IRQ_EN = 8'h00;
    localparam logic [7:0] GA_WD_TO  = 8'h01;
    localparam logic [7:0] GA_WD_CTL = 8'h02;
    localparam logic [7:0] GA_WD_CNT = 8'h03;

    typedef struct packed {
        logic mask;
        logic clr;
    } wd_ctl_t;

    // compare one sample against the three limits, all signed 16-bit
    function automatic logic [2:0] classify(input logic signed [15:0] t,
                                            input logic signed [15:0] lo,
                                            input logic signed [15:0] up,
                                            input logic signed [15:0] cr);
        logic [2:0] r;
        r[CLS_LO] = (t <= lo);
        r[CLS_UP] = (t >= up);
        r[CLS_CR] = (t >= cr);
        return r;
    endfunction

endpackage

// File: rtl/tlm_sensor_slice.sv
module tlm_sensor_slice
    import tlm_pkg::*;
#(
    parameter int TEMP_W   = 12,
    parameter int DATA_W   = 16,
    parameter int HOLD_CYC = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_hit_i,
    input  logic signed [TEMP_W-1:0] smp_temp_i,
    input  logic                     wr_en_i,
    input  logic [2:0]               field_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic [NUM_CLS-1:0]       stat_o,
    output logic [NUM_CLS-1:0]       mask_o
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic signed [TEMP_W-1:0] T_MIN = {1'b1, {(TEMP_W-1){1'b0}}};
    localparam logic signed [TEMP_W-1:0] T_MAX = {1'b0, {(TEMP_W-1){1'b1}}};

    logic signed [TEMP_W-1:0] thr_lo, thr_up, thr_cr, last_t;
    logic [NUM_CLS-1:0]       mask_q, clr_q, stat_q, hit_cls;
    logic [HW-1:0]            hold_q;
    logic                     seen_q;
    logic                     valid;

    assign hit_cls = classify(16'(smp_temp_i), 16'(thr_lo), 16'(thr_up), 16'(thr_cr));
    assign valid   = seen_q && (hold_q == '0);

    // limits and control
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_lo <= T_MIN;
            thr_up <= T_MAX;
            thr_cr <= T_MAX;
            mask_q <= '1;
            clr_q  <= '0;
        end else if (wr_en_i) begin
            case (field_i)
                FLD_LOW:  thr_lo <= wr_data_i[TEMP_W-1:0];
                FLD_UP:   thr_up <= wr_data_i[TEMP_W-1:0];
                FLD_CRIT: thr_cr <= wr_data_i[TEMP_W-1:0];
                FLD_CTRL: begin
                    mask_q <= wr_data_i[NUM_CLS-1:0];
                    clr_q  <= wr_data_i[2*NUM_CLS-1:NUM_CLS];
                end
                default: ;
            endcase
        end
    end

    // status, last value and valid hold timer
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            last_t <= '0;
            hold_q <= '0;
            seen_q <= 1'b0;
        end else begin
            for (int c = 0; c < NUM_CLS; c++) begin
                if (clr_q[c])       stat_q[c] <= 1'b0;
                else if (smp_hit_i) stat_q[c] <= hit_cls[c];
            end
            if (smp_hit_i) begin
                last_t <= smp_temp_i;
                hold_q <= HW'(HOLD_CYC);
                seen_q <= 1'b1;
            end else if (hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    always_comb begin
        case (field_i)
            FLD_LOW:  rd_data_o = DATA_W'(thr_lo);
            FLD_UP:   rd_data_o = DATA_W'(thr_up);
            FLD_CRIT: rd_data_o = DATA_W'(thr_cr);
            FLD_CTRL: rd_data_o = {{(DATA_W-2*NUM_CLS){1'b0}}, clr_q, mask_q};
            FLD_STAT: rd_data_o = {{(DATA_W-NUM_CLS-1){1'b0}}, valid, stat_q};
            FLD_LAST: rd_data_o = DATA_W'(last_t);
            default:  rd_data_o = '0;
        endcase
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        smp_hit_i |=> !valid) else $error("valid stayed high after sample"); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_q != '0) |=> ((stat_q & $past(clr_q)) == '0)) else $error("status survived clear"); // R5
    AST_STAT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q)) != '0) |-> $past(smp_hit_i)) else $error("status rose without sample"); // R2

endmodule

// File: rtl/tlm_bark_wd.sv
module tlm_bark_wd
    import tlm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_seen_i,
    input  logic [DATA_W-1:0] timeout_i,
    input  wd_ctl_t           ctl_i,
    output logic              bark_o,
    output logic [DATA_W-1:0] count_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] timer_q;
    logic              armed, expire;

    assign armed  = (timeout_i != '0);
    assign expire = armed && !smp_seen_i && (timer_q >= timeout_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            bark_o  <= 1'b0;
            count_o <= '0;
        end else begin
            if (!armed || smp_seen_i || expire) timer_q <= '0;
            else                                timer_q <= timer_q + 1'b1;
            if (ctl_i.clr)   bark_o <= 1'b0;
            else if (expire) bark_o <= 1'b1;
            if (expire && count_o != '1) count_o <= count_o + 1'b1;
        end
    end

    assign irq_o = bark_o && !ctl_i.mask;

    AST_BARK_COUNTS: assert property (@(posedge clk) disable iff (rst)
        $rose(bark_o) |-> (count_o == $past(count_o) + 1'b1) || ($past(count_o) == '1))
        else $error("bark without count step"); // R8
    AST_BARK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctl_i.clr |=> !bark_o) else $error("bark survived clear"); // R9

endmodule

// File: rtl/tlm_irq_merge.sv
module tlm_irq_merge
    import tlm_pkg::*;
#(
    parameter int NSENS = 12
) (
    input  logic [NUM_CLS*NSENS-1:0] stat_i,
    input  logic [NUM_CLS*NSENS-1:0] mask_i,
    input  logic [NUM_CLS-1:0]       en_i,
    output logic [NUM_CLS-1:0]       irq_o
);

    always_comb begin
        irq_o = '0;
        for (int i = 0; i < NSENS; i++)
            irq_o = irq_o | (stat_i[NUM_CLS*i +: NUM_CLS] & ~mask_i[NUM_CLS*i +: NUM_CLS]);
        irq_o = irq_o & en_i;
    end

endmodule

// File: rtl/thermal_limit_monitor.sv
module thermal_limit_monitor
    import tlm_pkg::*;
#(
    parameter int NSENS    = 12,
    parameter int ID_W     = 4,
    parameter int TEMP_W   = 12,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 8,
    parameter int HOLD_CYC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid_i,
    input  logic [ID_W-1:0]   smp_id_i,
    input  logic [TEMP_W-1:0] smp_temp_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_lower_o,
    output logic              irq_upper_o,
    output logic              irq_crit_o,
    output logic              irq_bark_o
);

    localparam int SLOT_W = ADDR_W - 4;

    logic                      sens_sel;
    logic [SLOT_W-1:0]         slot;
    logic [2:0]                field;
    logic [DATA_W-1:0]         slice_rd [NSENS];
    logic [NUM_CLS*NSENS-1:0]  stat_all, mask_all;
    logic [NUM_CLS-1:0]        irq_en_q, irq_vec;
    logic [DATA_W-1:0]         wd_to_q, wd_cnt;
    wd_ctl_t                   wd_ctl_q;
    logic                      bark;
    logic                      smp_ok;

    assign sens_sel = reg_addr_i[ADDR_W-1];
    assign slot     = reg_addr_i[ADDR_W-2:3];
    assign field    = reg_addr_i[2:0];
    assign smp_ok   = smp_valid_i && (int'(smp_id_i) < NSENS);

    for (genvar i = 0; i < NSENS; i++) begin : g_sens
        tlm_sensor_slice #(
            .TEMP_W(TEMP_W), .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)
        ) slice_i (
            .clk       (clk),
            .rst       (rst),
            .smp_hit_i (smp_valid_i && (smp_id_i == ID_W'(i))),
            .smp_temp_i(smp_temp_i),
            .wr_en_i   (reg_wr_i && sens_sel && (slot == SLOT_W'(i))),
            .field_i   (field),
            .wr_data_i (reg_wdata_i),
            .rd_data_o (slice_rd[i]),
            .stat_o    (stat_all[NUM_CLS*i +: NUM_CLS]),
            .mask_o    (mask_all[NUM_CLS*i +: NUM_CLS])
        );
    end

    // global registers
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q <= '0;
            wd_to_q  <= '0;
            wd_ctl_q <= '{mask: 1'b1, clr: 1'b0};
        end else if (reg_wr_i && !sens_sel) begin
            case (reg_addr_i)
                GA_IRQ_EN: irq_en_q <= reg_wdata_i[NUM_CLS-1:0];
                GA_WD_TO:  wd_to_q  <= reg_wdata_i;
                GA_WD_CTL: wd_ctl_q <= '{mask: reg_wdata_i[2], clr: reg_wdata_i[1]};
                default: ;
            endcase
        end
    end

    tlm_bark_wd #(.DATA_W(DATA_W)) wd_i (
        .clk       (clk),
        .rst       (rst),
        .smp_seen_i(smp_ok),
        .timeout_i (wd_to_q),
        .ctl_i     (wd_ctl_q),
        .bark_o    (bark),
        .count_o   (wd_cnt),
        .irq_o     (irq_bark_o)
    );

    tlm_irq_merge #(.NSENS(NSENS)) merge_i (
        .stat_i(stat_all),
        .mask_i(mask_all),
        .en_i  (irq_en_q),
        .irq_o (irq_vec)
    );

    assign irq_lower_o = irq_vec[CLS_LO];
    assign irq_upper_o = irq_vec[CLS_UP];
    assign irq_crit_o  = irq_vec[CLS_CR];

    always_comb begin
        reg_rdata_o = '0;
        if (sens_sel) begin
            if (int'(slot) < NSENS) reg_rdata_o = slice_rd[slot];
        end else begin
            case (reg_addr_i)
                GA_IRQ_EN: reg_rdata_o = DATA_W'(irq_en_q);
                GA_WD_TO:  reg_rdata_o = wd_to_q;
                GA_WD_CTL: reg_rdata_o = DATA_W'({wd_ctl_q.mask, wd_ctl_q.clr, bark});
                GA_WD_CNT: reg_rdata_o = wd_cnt;
                default:   reg_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: tb/thermal_limit_monitor_tb_top.sv
module thermal_limit_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_id = '0;
    logic [11:0] smp_temp = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_lo, irq_up, irq_cr, irq_bk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    thermal_limit_monitor dut_i (
        .clk(clk), .rst(rst),
        .smp_valid_i(smp_valid), .smp_id_i(smp_id), .smp_temp_i(smp_temp),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .irq_lower_o(irq_lo), .irq_upper_o(irq_up), .irq_crit_o(irq_cr), .irq_bark_o(irq_bk)
    );

    // {sensor, temp, expected {crit, upper, lower}}
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {4'd3,  16'sd200,   3'b000},
        {4'd3,  16'sd400,   3'b010},
        {4'd3,  16'sd399,   3'b000},
        {4'd3, -16'sd100,   3'b001},
        {4'd3, -16'sd101,   3'b001},
        {4'd3, -16'sd99,    3'b000},
        {4'd3,  16'sd900,   3'b110},
        {4'd3,  16'sd899,   3'b010},
        {4'd7,  16'sd300,   3'b110},
        {4'd7,  16'sd0,     3'b001},
        {4'd7,  16'sd1,     3'b000},
        {4'd7, -16'sd2048,  3'b001},
        {4'd7,  16'sd2047,  3'b110}
    };

    function automatic logic [7:0] sa(input int sid, input int fld);
        return 8'(8'h80 + sid * 8 + fld);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic smp(input int sid, input logic [15:0] t);
        @(negedge clk);
        smp_valid = 1'b1; smp_id = 4'(sid); smp_temp = t[11:0];
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(sa(0, 4), v);  chk("R1 status", v, 16'h0000);
        rd(sa(0, 3), v);  chk("R1 ctrl", v, 16'h0007);
        rd(sa(0, 0), v);  chk("R1 lower limit", v, 16'hF800);
        rd(8'h00, v);     chk("R1 enable", v, 16'h0000);
        rd(8'h02, v);     chk("R1 wd ctrl", v, 16'h0004);
        rd(8'h03, v);     chk("R1 bark count", v, 16'h0000);
        chk("R1 irqs", {12'h0, irq_bk, irq_cr, irq_up, irq_lo}, 16'h0000);

        // limits: sensor 3 -100/400/900, sensor 7 0/250/300
        wr(sa(3, 0), -16'sd100); wr(sa(3, 1), 16'd400); wr(sa(3, 2), 16'd900);
        wr(sa(7, 0), 16'd0);     wr(sa(7, 1), 16'd250); wr(sa(7, 2), 16'd300);

        // R2 / R7 vector walk
        for (int k = 0; k < NV; k++) begin
            smp(int'(VEC[k][22:19]), VEC[k][18:3]);
            rd(sa(int'(VEC[k][22:19]), 4), v);
            chk($sformatf("R2 vec%0d status", k), {13'h0, v[2:0]}, {13'h0, VEC[k][2:0]});
            rd(sa(int'(VEC[k][22:19]), 5), v);
            chk($sformatf("R7 vec%0d last", k), v, VEC[k][18:3]);
        end

        // R6 valid timing on untouched sensor 5
        rd(sa(5, 4), v); chk("R6 valid before first sample", {15'h0, v[3]}, 16'h0000);
        smp(5, 16'd10);
        rd(sa(5, 4), v); chk("R6 valid low after sample", {15'h0, v[3]}, 16'h0000);
        repeat (5) @(negedge clk);
        rd(sa(5, 4), v); chk("R6 valid low at 5 cycles", {15'h0, v[3]}, 16'h0000);
        @(negedge clk);
        rd(sa(5, 4), v); chk("R6 valid high at 6 cycles", {15'h0, v[3]}, 16'h0001);

        // R3 level interrupts
        wr(8'h00, 16'h0007);
        wr(sa(3, 3), 16'h0000);
        smp(3, 16'd500);
        chk("R3 upper raised", {13'h0, irq_cr, irq_up, irq_lo}, 16'h0002);
        smp(3, 16'd100);
        chk("R3 upper drops in range", {13'h0, irq_cr, irq_up, irq_lo}, 16'h0000);
        smp(3, 16'd950);
        chk("R3 upper+crit", {13'h0, irq_cr, irq_up, irq_lo}, 16'h0006);
        smp(7, 16'd0);
        chk("R4 masked sensor7 lower", {13'h0, irq_cr, irq_up, irq_lo}, 16'h0006);

        // R4 mask
        wr(sa(3, 3), 16'h0002);
        chk("R4 upper masked", {13'h0, irq_cr, irq_up, irq_lo}, 16'h0004);
        wr(8'h00, 16'h0003);
        chk("R3 crit disabled", {13'h0, irq_cr, irq_up, irq_lo}, 16'h0000);

        // R5 clear
        wr(sa(3, 3), 16'h003F);
        @(negedge clk);
        rd(sa(3, 4), v); chk("R5 status cleared", {13'h0, v[2:0]}, 16'h0000);
        smp(3, 16'd950);
        rd(sa(3, 4), v); chk("R5 sample ignored while clear", {13'h0, v[2:0]}, 16'h0000);
        wr(sa(3, 3), 16'h0000);
        @(negedge clk);
        rd(sa(3, 4), v); chk("R5 stays zero after release", {13'h0, v[2:0]}, 16'h0000);
        smp(3, 16'd950);
        rd(sa(3, 4), v); chk("R5 next sample sets", {13'h0, v[2:0]}, 16'h0006);
        repeat (7) @(negedge clk);

        // R10 out of range sensor
        smp(13, 16'hFE0C);
        rd(sa(3, 4), v); chk("R10 sensor3 status and valid kept", v, 16'h000E);
        rd(sa(3, 5), v); chk("R10 sensor3 last kept", v, 16'd950);

        // R8 / R9 watchdog
        wr(8'h01, 16'd20);
        smp(3, 16'd0);
        repeat (19) @(negedge clk);
        rd(8'h02, v); chk("R8 no bark at T-1", {15'h0, v[0]}, 16'h0000);
        @(negedge clk);
        rd(8'h02, v); chk("R8 bark at T", {15'h0, v[0]}, 16'h0001);
        rd(8'h03, v); chk("R8 count one", v, 16'h0001);
        chk("R9 masked bark irq", {15'h0, irq_bk}, 16'h0000);
        wr(8'h02, 16'h0000);
        chk("R9 unmasked bark irq", {15'h0, irq_bk}, 16'h0001);
        wr(8'h02, 16'h0002);
        wr(8'h02, 16'h0000);
        rd(8'h02, v); chk("R9 bark cleared", {15'h0, v[0]}, 16'h0000);
        rd(8'h03, v); chk("R9 count kept", v, 16'h0001);
        chk("R9 irq dropped", {15'h0, irq_bk}, 16'h0000);
        wr(8'h01, 16'd0);
        repeat (40) @(negedge clk);
        rd(8'h03, v); chk("R8 timeout zero disables", v, 16'h0001);

        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule